// File: doc/BRIEF.md
# SPI Completion Interrupt and DMA Burst Request Unit

This unit sits next to a serial peripheral engine and turns its two completion pulses (transmit finished, receive finished) into a sticky status word, a per-source enable, a masked view and one level interrupt line. Software clears status bits by writing ones to a clear port. Status set by a new event wins over a clear that arrives in the same cycle, so no completion is lost.

The same unit paces an external DMA controller. Each direction has a one-cycle burst request. A request carries one fragment of eight words, which is 8, 16 or 32 bytes depending on the configured word size. A receive transfer longer than one fragment is cut down to a whole number of fragments for DMA. The words left over stay in the receive FIFO, and the processor reads them after the receive-end event. The leftover count is reported so software knows how many words to read.

Top module: `spiIrqDmaReq`

## Requirements
- R1: A write with `wrSel`=0 loads the enable bits from `wrData[8]` (transmit end) and `wrData[9]` (receive end). `intEnReg` shows them at those bit positions and all other bits of `intEnReg` are zero. Writing zero masks both sources at once while the raw bits stay unchanged.
- R2: A `txEndEvt` pulse sets `rawSts[8]`, and a `rxEndEvt` pulse sets `rawSts[9]`, on the next clock edge. A set bit holds until it is cleared. All other bits of `rawSts` are zero.
- R3: A write with `wrSel`=1 clears each raw bit whose position (8 or 9) holds a one in `wrData`. Zero bits in `wrData` leave the raw bits unchanged.
- R4: If an event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R5: `maskSts` equals `rawSts` ANDed with `intEnReg`, and `irqOut` is high exactly when some bit of `maskSts` is set.
- R6: A write with `wrSel`=2 loads the DMA enable from `wrData[6]`. While the enable is clear, neither `dmaTxReq` nor `dmaRxReq` ever pulses. Writes with `wrSel`=3 have no effect.
- R7: `burstBytes` is 8, 16 or 32 for `wordSize` 0, 1 or 2. The value 3 gives 32.
- R8: `xferLoad` sets the receive DMA quota from `xferWords`. A length above 8 is rounded down to a multiple of 8, and a length of 8 or less is kept as is. `rxTail` shows the words that are not covered by the quota, from the cycle after the load.
- R9: The receive request is a one-cycle pulse. It is issued when the quota is nonzero, no burst is outstanding, and `rxFifoLevel` is at least min(8, quota). The burst stays outstanding until `dmaRxAck`, and the ack takes that many words off the quota.
- R10: The transmit request is a one-cycle pulse. It is issued when words remain, no burst is outstanding, and `txFifoFree` is at least 8. `dmaTxAck` ends the burst and takes min(8, remaining) words off the remaining count.
- R11: After reset all outputs except `burstBytes` are zero, and the DMA enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 enable, 1 clear, 2 DMA control, 3 none |
| wrData | input | 16 | Write data |
| txEndEvt | input | 1 | Transmit-complete pulse from the engine |
| rxEndEvt | input | 1 | Receive-complete pulse from the engine |
| wordSize | input | 2 | Word size: 0 8-bit, 1 16-bit, 2/3 32-bit |
| xferLoad | input | 1 | Loads a new transfer length |
| xferWords | input | 20 | Transfer length in words |
| txFifoFree | input | 6 | Free entries in the transmit FIFO |
| rxFifoLevel | input | 6 | Filled entries in the receive FIFO |
| dmaTxAck | input | 1 | Transmit burst finished |
| dmaRxAck | input | 1 | Receive burst finished |
| intEnReg | output | 16 | Enable register view |
| rawSts | output | 16 | Raw status view |
| maskSts | output | 16 | Masked status view |
| irqOut | output | 1 | Interrupt line |
| dmaTxReq | output | 1 | Transmit burst request pulse |
| dmaRxReq | output | 1 | Receive burst request pulse |
| burstBytes | output | 6 | Bytes per fragment |
| rxTail | output | 20 | Receive words left for processor reads |

## Verification
The properties assume that the DMA controller acknowledges a burst only after it has seen that burst's request, and only once per request. They also assume that the FIFO levels never exceed the FIFO depth. The random phase drives only the event pulses and the enable and clear writes, where any pattern is legal, including simultaneous set and clear. The request/acknowledge exchange is driven by directed sequences that raise each acknowledge for exactly one cycle after a request has been seen.

// File: rtl/spi_irq_dma_pkg.sv
package spi_irq_dma_pkg;
  localparam int TX_END_BIT = 8;
  localparam int RX_END_BIT = 9;
  localparam int DMA_EN_BIT = 6;

  typedef enum logic [1:0] {
    SEL_INT_EN  = 2'd0,
    SEL_INT_CLR = 2'd1,
    SEL_DMA_CTL = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  // index 0 = transmit end, index 1 = receive end
  typedef struct packed {
    logic       enWr;
    logic [1:0] enVal;
    logic [1:0] clrMask;
    logic       ctlWr;
    logic       dmaEnVal;
  } regStrobe_t;
endpackage

// File: rtl/spiIrqDecode.sv
module spiIrqDecode
  import spi_irq_dma_pkg::*;
(
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [15:0] wrData,
  output regStrobe_t  strb
);
  regSel_e selE;
  logic    wrDataUnused;

  assign selE = regSel_e'(wrSel);
  assign wrDataUnused = ^{wrData[15:10], wrData[7], wrData[5:0]};

  always_comb begin
    strb          = '0;
    strb.enVal    = {wrData[RX_END_BIT], wrData[TX_END_BIT]};
    strb.dmaEnVal = wrData[DMA_EN_BIT];
    if (wrEn) begin
      unique case (selE)
        SEL_INT_EN:  strb.enWr    = 1'b1;
        SEL_INT_CLR: strb.clrMask = {wrData[RX_END_BIT], wrData[TX_END_BIT]};
        SEL_DMA_CTL: strb.ctlWr   = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/spiIrqStatus.sv
module spiIrqStatus
  import spi_irq_dma_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evt,
  input  regStrobe_t         strb,
  output logic [NUM_SRC-1:0] enQ,
  output logic [NUM_SRC-1:0] rawQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= '0;
    else if (strb.enWr) enQ <= strb.enVal[NUM_SRC-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rawQ[g] <= 1'b0;
      else if (evt[g]) rawQ[g] <= 1'b1;
      else if (strb.clrMask[g]) rawQ[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/spiDmaReq.sv
module spiDmaReq #(
  parameter int FRAG_WORDS = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W      = 20,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int BB_W      = $clog2(FRAG_WORDS * 4 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dmaEnWr,
  input  logic             dmaEnVal,
  input  logic [1:0]       wordSize,
  input  logic             xferLoad,
  input  logic [LEN_W-1:0] xferWords,
  input  logic [LVL_W-1:0] txFifoFree,
  input  logic [LVL_W-1:0] rxFifoLevel,
  input  logic             txAck,
  input  logic             rxAck,
  output logic             txReq,
  output logic             rxReq,
  output logic             dmaEn,
  output logic [BB_W-1:0]  burstBytes,
  output logic [LEN_W-1:0] rxTail
);
  localparam logic [LEN_W-1:0] FRAG_L = LEN_W'(FRAG_WORDS);

  logic [LEN_W-1:0] txRemain, rxQuota, fragRem, loadRxQuota;
  logic [LEN_W-1:0] txNeed, rxNeed;
  logic             txBusy, rxBusy, txGo, rxGo;

  if ((FRAG_WORDS & (FRAG_WORDS - 1)) == 0) begin : gPow2
    assign fragRem = xferWords & (FRAG_L - 1'b1);
  end else begin : gAny
    assign fragRem = xferWords % FRAG_L;
  end

  assign loadRxQuota = (xferWords > FRAG_L) ? (xferWords - fragRem) : xferWords;

  always_comb begin
    unique case (wordSize)
      2'd0:    burstBytes = BB_W'(FRAG_WORDS);
      2'd1:    burstBytes = BB_W'(FRAG_WORDS * 2);
      default: burstBytes = BB_W'(FRAG_WORDS * 4);
    endcase
  end

  assign txNeed = (txRemain > FRAG_L) ? FRAG_L : txRemain;
  assign rxNeed = (rxQuota > FRAG_L) ? FRAG_L : rxQuota;
  assign txGo   = (txRemain != '0) && (LEN_W'(txFifoFree) >= FRAG_L);
  assign rxGo   = (rxQuota != '0) && (LEN_W'(rxFifoLevel) >= rxNeed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReq <= 1'b0; rxReq <= 1'b0;
      txBusy <= 1'b0; rxBusy <= 1'b0;
      txRemain <= '0; rxQuota <= '0; rxTail <= '0;
      dmaEn <= 1'b0;
    end else begin
      txReq <= 1'b0;
      rxReq <= 1'b0;
      if (dmaEnWr) dmaEn <= dmaEnVal;
      if (xferLoad) begin
        txRemain <= xferWords;
        rxQuota  <= loadRxQuota;
        rxTail   <= xferWords - loadRxQuota;
        txBusy   <= 1'b0;
        rxBusy   <= 1'b0;
      end else begin
        if (txBusy) begin
          if (txAck) begin
            txBusy   <= 1'b0;
            txRemain <= txRemain - txNeed;
          end
        end else if (dmaEn && txGo) begin
          txReq  <= 1'b1;
          txBusy <= 1'b1;
        end
        if (rxBusy) begin
          if (rxAck) begin
            rxBusy  <= 1'b0;
            rxQuota <= rxQuota - rxNeed;
          end
        end else if (dmaEn && rxGo) begin
          rxReq  <= 1'b1;
          rxBusy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spiIrqDmaReq.sv
module spiIrqDmaReq
  import spi_irq_dma_pkg::*;
#(
  parameter int FRAG_WORDS = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W      = 20
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [1:0]                        wrSel,
  input  logic [15:0]                       wrData,
  input  logic                              txEndEvt,
  input  logic                              rxEndEvt,
  input  logic [1:0]                        wordSize,
  input  logic                              xferLoad,
  input  logic [LEN_W-1:0]                  xferWords,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   txFifoFree,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   rxFifoLevel,
  input  logic                              dmaTxAck,
  input  logic                              dmaRxAck,
  output logic [15:0]                       intEnReg,
  output logic [15:0]                       rawSts,
  output logic [15:0]                       maskSts,
  output logic                              irqOut,
  output logic                              dmaTxReq,
  output logic                              dmaRxReq,
  output logic [$clog2(FRAG_WORDS*4+1)-1:0] burstBytes,
  output logic [LEN_W-1:0]                  rxTail
);
  regStrobe_t strb;
  logic [1:0] enQ, rawQ, maskQ;
  logic       dmaEn;

  spiIrqDecode uDecode (.wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .strb(strb));

  spiIrqStatus #(.NUM_SRC(2)) uStatus (
    .clk(clk), .rstN(rstN), .evt({rxEndEvt, txEndEvt}), .strb(strb),
    .enQ(enQ), .rawQ(rawQ)
  );

  spiDmaReq #(.FRAG_WORDS(FRAG_WORDS), .FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) uDma (
    .clk(clk), .rstN(rstN), .dmaEnWr(strb.ctlWr), .dmaEnVal(strb.dmaEnVal),
    .wordSize(wordSize), .xferLoad(xferLoad), .xferWords(xferWords),
    .txFifoFree(txFifoFree), .rxFifoLevel(rxFifoLevel),
    .txAck(dmaTxAck), .rxAck(dmaRxAck), .txReq(dmaTxReq), .rxReq(dmaRxReq),
    .dmaEn(dmaEn), .burstBytes(burstBytes), .rxTail(rxTail)
  );

  assign maskQ  = rawQ & enQ;
  assign irqOut = |maskQ;

  always_comb begin
    intEnReg = '0;
    rawSts   = '0;
    maskSts  = '0;
    intEnReg[TX_END_BIT] = enQ[0];
    intEnReg[RX_END_BIT] = enQ[1];
    rawSts[TX_END_BIT]   = rawQ[0];
    rawSts[RX_END_BIT]   = rawQ[1];
    maskSts[TX_END_BIT]  = maskQ[0];
    maskSts[RX_END_BIT]  = maskQ[1];
  end
endmodule

module spiIrqDmaReq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrSel,
  input logic [15:0] wrData,
  input logic        txEndEvt,
  input logic        rxEndEvt,
  input logic [15:0] intEnReg,
  input logic [15:0] rawSts,
  input logic        irqOut,
  input logic        dmaTxReq,
  input logic        dmaRxReq,
  input logic        dmaEn
);
  // R1
  en_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0) |=> (intEnReg == {6'd0, $past(wrData[9:8]), 8'd0}));
  // R2
  tx_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEndEvt |=> rawSts[8]);
  // R3
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1 && wrData[8] && !txEndEvt) |=> !rawSts[8]);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEndEvt && wrEn && wrSel == 2'd1 && wrData[9]) |=> rawSts[9]);
  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((rawSts & intEnReg) != 16'd0));
  // R6
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaTxReq || dmaRxReq) |-> $past(dmaEn));
  // R9
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaRxReq |=> !dmaRxReq);
  // R10
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaTxReq |=> !dmaTxReq);
endmodule

bind spiIrqDmaReq spiIrqDmaReq_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .txEndEvt(txEndEvt), .rxEndEvt(rxEndEvt), .intEnReg(intEnReg),
  .rawSts(rawSts), .irqOut(irqOut), .dmaTxReq(dmaTxReq),
  .dmaRxReq(dmaRxReq), .dmaEn(dmaEn)
);

// File: tb/tb_spiIrqDmaReq.sv
module tb_spiIrqDmaReq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [15:0] wrData = '0;
  logic        txEndEvt = 1'b0, rxEndEvt = 1'b0;
  logic [1:0]  wordSize = 2'd0;
  logic        xferLoad = 1'b0;
  logic [19:0] xferWords = '0;
  logic [5:0]  txFifoFree = '0, rxFifoLevel = '0;
  logic        dmaTxAck = 1'b0, dmaRxAck = 1'b0;
  logic [15:0] intEnReg, rawSts, maskSts;
  logic        irqOut, dmaTxReq, dmaRxReq;
  logic [5:0]  burstBytes;
  logic [19:0] rxTail;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  logic [1:0] mRaw = '0, mEn = '0;

  always #10 clk = ~clk;

  spiIrqDmaReq dut (.*);

  function automatic logic [15:0] place(input logic [1:0] v);
    return {6'd0, v, 8'd0};
  endfunction
  function automatic logic [19:0] expQuota(input logic [19:0] len);
    return (len > 20'd8) ? (len - (len % 20'd8)) : len;
  endfunction
  function automatic logic [5:0] expBurst(input logic [1:0] ws);
    return (ws == 2'd0) ? 6'd8 : (ws == 2'd1) ? 6'd16 : 6'd32;
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic regWrite(input logic [1:0] sel, input logic [15:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    tick();
    wrEn = 1'b0; wrSel = 2'd3; wrData = '0;
  endtask
  task automatic load(input logic [19:0] n);
    xferWords = n; xferLoad = 1'b1;
    tick();
    xferLoad = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(); tick();
    // R11 reset state
    chk("R11 intEnReg", intEnReg, 0);
    chk("R11 rawSts", rawSts, 0);
    chk("R11 irqOut", irqOut, 0);
    chk("R11 dmaRxReq", dmaRxReq, 0);
    rstN = 1'b1;
    tick();
    chk("R11 rxTail", rxTail, 0);

    // R2 event sets raw, R5 masked stays zero with enables clear
    txEndEvt = 1'b1; tick(); txEndEvt = 1'b0;
    chk("R2 tx raw", rawSts, place(2'b01));
    chk("R5 masked off", maskSts, 0);
    // R4 simultaneous set and clear of bit 9
    rxEndEvt = 1'b1; wrEn = 1'b1; wrSel = 2'd1; wrData = 16'h0200;
    tick();
    rxEndEvt = 1'b0; wrEn = 1'b0; wrSel = 2'd3; wrData = '0;
    chk("R4 set wins", rawSts, place(2'b11));
    // R3 zeros do nothing, ones clear
    regWrite(2'd1, 16'hFCFF);
    chk("R3 zero bits keep", rawSts, place(2'b11));
    // R1 enable then mask all with zero
    regWrite(2'd0, 16'hFFFF);
    chk("R1 enable view", intEnReg, place(2'b11));
    chk("R5 irq on", irqOut, 1);
    regWrite(2'd0, 16'h0000);
    chk("R1 zero masks irq", irqOut, 0);
    chk("R1 raw kept", rawSts, place(2'b11));
    regWrite(2'd1, 16'h0100);
    chk("R3 clear tx only", rawSts, place(2'b10));
    regWrite(2'd1, 16'h0200);
    mRaw = '0; mEn = '0;

    // random phase: R2 R3 R4 R5 R1
    for (int i = 0; i < 400; i++) begin
      logic [1:0] setV, clrV, sel;
      logic we;
      logic [15:0] d;
      setV = 2'($urandom_range(0, 3)) & {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
      we = ($urandom_range(0, 2) == 0);
      sel = 2'($urandom_range(0, 2));
      if (sel == 2'd2) sel = 2'd3;
      d = 16'($urandom());
      txEndEvt = setV[0]; rxEndEvt = setV[1];
      wrEn = we; wrSel = sel; wrData = d;
      clrV = (we && sel == 2'd1) ? d[9:8] : 2'b00;
      mRaw = (mRaw & ~clrV) | setV;
      if (we && sel == 2'd0) mEn = d[9:8];
      tick();
      chk("R2/R3/R4 raw", rawSts, place(mRaw));
      chk("R1 enable", intEnReg, place(mEn));
      chk("R5 masked", maskSts, place(mRaw & mEn));
      chk("R5 irq", irqOut, |(mRaw & mEn));
    end
    txEndEvt = 0; rxEndEvt = 0; wrEn = 0; wrSel = 2'd3; wrData = '0;

    // R7 burst sizes
    for (int w = 0; w < 4; w++) begin
      wordSize = 2'(w); tick();
      chk("R7 burstBytes", burstBytes, expBurst(2'(w)));
    end
    wordSize = 2'd0;

    // R8 quota rounding and tail
    begin
      logic [19:0] lens [5] = '{20'd21, 20'd5, 20'd16, 20'd8, 20'd9};
      for (int k = 0; k < 5; k++) begin
        load(lens[k]);
        chk("R8 rxTail", rxTail, lens[k] - expQuota(lens[k]));
      end
    end

    // R6 requests blocked while DMA disabled (also wrSel 3 ignored)
    rxFifoLevel = 6'd32; txFifoFree = 6'd32;
    regWrite(2'd3, 16'hFFFF);
    load(20'd20);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 no tx req", dmaTxReq, 0);
      chk("R6 no rx req", dmaRxReq, 0);
    end
    rxFifoLevel = 0; txFifoFree = 0;
    regWrite(2'd2, 16'h0040);

    // R9 receive pacing, length 21 -> quota 16
    load(20'd21);
    chk("R8 tail 21", rxTail, 5);
    rxFifoLevel = 6'd7; tick(); tick();
    chk("R9 below fragment", dmaRxReq, 0);
    rxFifoLevel = 6'd8; tick();
    chk("R9 first req", dmaRxReq, 1);
    tick();
    chk("R9 pulse ends", dmaRxReq, 0);
    tick();
    chk("R9 held while outstanding", dmaRxReq, 0);
    dmaRxAck = 1; tick(); dmaRxAck = 0;
    tick();
    chk("R9 second req", dmaRxReq, 1);
    dmaRxAck = 0; tick();
    dmaRxAck = 1; tick(); dmaRxAck = 0;
    tick(); tick();
    chk("R9 quota used up", dmaRxReq, 0);

    // R9 short transfer: request at level >= length
    rxFifoLevel = 0;
    load(20'd5);
    rxFifoLevel = 6'd4; tick(); tick();
    chk("R9 short below", dmaRxReq, 0);
    rxFifoLevel = 6'd5; tick();
    chk("R9 short req", dmaRxReq, 1);
    dmaRxAck = 1; tick(); dmaRxAck = 0;
    rxFifoLevel = 0;

    // R10 transmit pacing, length 10
    load(20'd10);
    txFifoFree = 6'd7; tick(); tick();
    chk("R10 no room", dmaTxReq, 0);
    txFifoFree = 6'd8; tick();
    chk("R10 first req", dmaTxReq, 1);
    tick();
    dmaTxAck = 1; tick(); dmaTxAck = 0;
    tick();
    chk("R10 second req", dmaTxReq, 1);
    tick();
    dmaTxAck = 1; tick(); dmaTxAck = 0;
    tick(); tick();
    chk("R10 all sent", dmaTxReq, 0);

    // R6 clearing enable stops requests
    regWrite(2'd2, 16'h0000);
    load(20'd16);
    rxFifoLevel = 6'd32;
    tick(); tick();
    chk("R6 disabled rx", dmaRxReq, 0);
    chk("R6 disabled tx", dmaTxReq, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule